// File: doc/BRIEF.md
# Operand Forwarding Network

This block picks the source operand for the decode stage of a four-wide, four-stage pipeline. It sees the value read from the register file and eight in-flight results. Four results come from the execute stage (slots 0 to 3) and four from the write-back stage (slots 0 to 3). Each result carries a 16-bit value, a 6-bit destination register number and a valid flag.

One comparator per in-flight result checks its destination against the 6-bit source register number of the decode stage. A priority encoder turns the comparator hits into a 4-bit select code. That code steers a nine-way multiplexer, which drives the operand.

A parameter adds a registered output stage. With it, the select code and the operand appear one clock after their inputs and are cleared by reset. By default the stage is present. Without it the block is purely combinational. Stalls and register-file writes are handled elsewhere.

Top module: `fwd_net`

## Requirements
- R1: When no valid entry has a destination equal to the source number, sel_o is 0 and operand_o equals rf_data_i.
- R2: A valid entry whose destination equals the source number is forwarded. sel_o is 1 to 4 for execute slots 0 to 3 and 5 to 8 for write-back slots 0 to 3. operand_o is that entry's data.
- R3: An entry whose valid bit is 0 is never forwarded, whatever its destination number.
- R4: A match needs all 6 register bits equal. A destination that differs from the source in any single bit is not forwarded.
- R5: When both stages hold a valid match, the execute-stage entry is chosen.
- R6: Among valid matches in the same stage, the lowest slot index is chosen.
- R7: With OUT_REG=1, sel_o and operand_o reflect the inputs present at the previous rising clock edge. While rst_ni is low, both outputs are 0.
- R8: sel_o never takes a value above 8. Codes 9 to 15 would drive operand_o to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output stage |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_reg_i | input | 6 | Source register number in decode |
| rf_data_i | input | 16 | Register file read value |
| ex_data_i | input | 64 | Execute results, slot k at bits [16k+15:16k] |
| ex_dst_i | input | 24 | Execute destinations, slot k at bits [6k+5:6k] |
| ex_vld_i | input | 4 | Execute valid flags, bit k for slot k |
| wb_data_i | input | 64 | Write-back results, slot k at bits [16k+15:16k] |
| wb_dst_i | input | 24 | Write-back destinations, slot k at bits [6k+5:6k] |
| wb_vld_i | input | 4 | Write-back valid flags, bit k for slot k |
| sel_o | output | 4 | Chosen source code |
| operand_o | output | 16 | Forwarded operand |

## Verification
The tests on the forwarding path itself start with a single valid match placed in each of the eight slots in turn, with the other entries valid but not matching. This separates each select code and each data lane. Fully matching but invalid entries show whether the valid qualification works. Destinations one bit away from the source, for each of the six bits and for sources 0 and 63, show a comparator that ignores a bit.

The priority tests use overlapping matches: one in each stage, two in one stage, and all eight at once. These pin down the order between stages and between slots.

A long random run over a small register range makes frequent multi-hit cases. Each result is compared with a behavioural model one clock later.

// File: rtl/fwd_pkg.sv
`timescale 1ns/1ps
package fwd_pkg;
  localparam int unsigned DEF_DATA_W = 16;
  localparam int unsigned DEF_REG_W  = 6;
  localparam int unsigned DEF_NUM_EX = 4;
  localparam int unsigned DEF_NUM_WB = 4;

  function automatic int unsigned sel_width(input int unsigned n_src);
    return (n_src < 2) ? 1 : $clog2(n_src);
  endfunction
endpackage

// File: rtl/fwd_cmp.sv
`timescale 1ns/1ps
module fwd_cmp #(
  parameter int unsigned REG_W = 6,
  parameter int unsigned N     = 8
) (
  input  logic [REG_W-1:0]   src_i,
  input  logic [N*REG_W-1:0] dst_i,
  input  logic [N-1:0]       vld_i,
  output logic [N-1:0]       hit_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_o[g] = vld_i[g] && (dst_i[g*REG_W +: REG_W] == src_i);
  end
endmodule

// File: rtl/fwd_enc.sv
`timescale 1ns/1ps
// Index 0 has highest priority; code = index + 1, code 0 = no hit.
module fwd_enc #(
  parameter int unsigned N     = 8,
  parameter int unsigned SEL_W = 4
) (
  input  logic [N-1:0]     hit_i,
  output logic [SEL_W-1:0] sel_o
);
  always_comb begin
    sel_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_i[i]) sel_o = SEL_W'(i + 1);
    end
  end
endmodule

// File: rtl/fwd_mux.sv
`timescale 1ns/1ps
module fwd_mux #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned N      = 8,
  parameter int unsigned SEL_W  = 4
) (
  input  logic [DATA_W-1:0]   rf_i,
  input  logic [N*DATA_W-1:0] data_i,
  input  logic [SEL_W-1:0]    sel_i,
  output logic [DATA_W-1:0]   out_o
);
  always_comb begin
    out_o = '0;  // unused codes give 0
    if (sel_i == '0) out_o = rf_i;
    for (int i = 0; i < N; i++) begin
      if (sel_i == SEL_W'(i + 1)) out_o = data_i[i*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/fwd_net.sv
`timescale 1ns/1ps
module fwd_net #(
  parameter int unsigned DATA_W  = fwd_pkg::DEF_DATA_W,
  parameter int unsigned REG_W   = fwd_pkg::DEF_REG_W,
  parameter int unsigned NUM_EX  = fwd_pkg::DEF_NUM_EX,
  parameter int unsigned NUM_WB  = fwd_pkg::DEF_NUM_WB,
  parameter bit          OUT_REG = 1'b1,
  localparam int unsigned N      = NUM_EX + NUM_WB,
  localparam int unsigned SEL_W  = fwd_pkg::sel_width(N + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [REG_W-1:0]         src_reg_i,
  input  logic [DATA_W-1:0]        rf_data_i,
  input  logic [NUM_EX*DATA_W-1:0] ex_data_i,
  input  logic [NUM_EX*REG_W-1:0]  ex_dst_i,
  input  logic [NUM_EX-1:0]        ex_vld_i,
  input  logic [NUM_WB*DATA_W-1:0] wb_data_i,
  input  logic [NUM_WB*REG_W-1:0]  wb_dst_i,
  input  logic [NUM_WB-1:0]        wb_vld_i,
  output logic [SEL_W-1:0]         sel_o,
  output logic [DATA_W-1:0]        operand_o
);
  // execute entries occupy the low indices, so they take priority
  logic [N*DATA_W-1:0] all_data;
  logic [N*REG_W-1:0]  all_dst;
  logic [N-1:0]        all_vld;
  logic [N-1:0]        hit;
  logic [SEL_W-1:0]    sel_d;
  logic [DATA_W-1:0]   op_d;

  assign all_data = {wb_data_i, ex_data_i};
  assign all_dst  = {wb_dst_i, ex_dst_i};
  assign all_vld  = {wb_vld_i, ex_vld_i};

  fwd_cmp #(.REG_W(REG_W), .N(N)) u_cmp (
    .src_i (src_reg_i),
    .dst_i (all_dst),
    .vld_i (all_vld),
    .hit_o (hit)
  );

  fwd_enc #(.N(N), .SEL_W(SEL_W)) u_enc (
    .hit_i (hit),
    .sel_o (sel_d)
  );

  fwd_mux #(.DATA_W(DATA_W), .N(N), .SEL_W(SEL_W)) u_mux (
    .rf_i   (rf_data_i),
    .data_i (all_data),
    .sel_i  (sel_d),
    .out_o  (op_d)
  );

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sel_o     <= '0;
        operand_o <= '0;
      end else begin
        sel_o     <= sel_d;
        operand_o <= op_d;
      end
    end
  end else begin : g_comb
    assign sel_o     = sel_d;
    assign operand_o = op_d;
  end
endmodule

// File: rtl/fwd_net_chk.sv
`timescale 1ns/1ps
module fwd_net_chk #(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned REG_W   = 6,
  parameter int unsigned NUM_EX  = 4,
  parameter int unsigned NUM_WB  = 4,
  parameter bit          OUT_REG = 1'b1,
  localparam int unsigned N      = NUM_EX + NUM_WB,
  localparam int unsigned SEL_W  = fwd_pkg::sel_width(N + 1)
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [REG_W-1:0]         src_reg_i,
  input logic [DATA_W-1:0]        rf_data_i,
  input logic [NUM_EX*DATA_W-1:0] ex_data_i,
  input logic [NUM_EX*REG_W-1:0]  ex_dst_i,
  input logic [NUM_EX-1:0]        ex_vld_i,
  input logic [NUM_WB*DATA_W-1:0] wb_data_i,
  input logic [NUM_WB*REG_W-1:0]  wb_dst_i,
  input logic [NUM_WB-1:0]        wb_vld_i,
  input logic [SEL_W-1:0]         sel_o,
  input logic [DATA_W-1:0]        operand_o
);
  logic [N*DATA_W-1:0] c_data, r_data;
  logic [N*REG_W-1:0]  c_dst, r_dst;
  logic [N-1:0]        c_vld, r_vld;
  logic [REG_W-1:0]    r_src;
  logic [DATA_W-1:0]   r_rf;
  logic                ok;

  assign c_data = {wb_data_i, ex_data_i};
  assign c_dst  = {wb_dst_i, ex_dst_i};
  assign c_vld  = {wb_vld_i, ex_vld_i};

  if (OUT_REG) begin : g_ref
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        r_data <= '0; r_dst <= '0; r_vld <= '0; r_src <= '0; r_rf <= '0; ok <= 1'b0;
      end else begin
        r_data <= c_data; r_dst <= c_dst; r_vld <= c_vld;
        r_src <= src_reg_i; r_rf <= rf_data_i; ok <= 1'b1;
      end
    end
    // R7
    reset_clear_chk: assert property (@(posedge clk_i)
      !rst_ni |-> (sel_o == '0 && operand_o == '0));
  end else begin : g_ref
    assign r_data = c_data;
    assign r_dst  = c_dst;
    assign r_vld  = c_vld;
    assign r_src  = src_reg_i;
    assign r_rf   = rf_data_i;
    assign ok     = 1'b1;
  end

  logic any_hit, ex_hit, pick_good, earlier_hit;
  always_comb begin
    any_hit = 1'b0; ex_hit = 1'b0; pick_good = 1'b0; earlier_hit = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (r_vld[i] && r_dst[i*REG_W +: REG_W] == r_src) begin
        any_hit = 1'b1;
        if (i < NUM_EX) ex_hit = 1'b1;
        if (i + 1 < int'(sel_o)) earlier_hit = 1'b1;
      end
      if (sel_o == SEL_W'(i + 1))
        pick_good = r_vld[i] && (r_dst[i*REG_W +: REG_W] == r_src)
                    && (operand_o == r_data[i*DATA_W +: DATA_W]);
    end
  end

  // R1
  no_hit_rf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok && !any_hit |-> (sel_o == '0 && operand_o == r_rf));
  // R2
  hit_forwards_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok && any_hit |-> sel_o != '0);
  // R3
  valid_match_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok && sel_o != '0 |-> pick_good);
  // R5
  ex_over_wb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok && ex_hit |-> (sel_o >= SEL_W'(1) && sel_o <= SEL_W'(NUM_EX)));
  // R6
  lowest_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok && sel_o != '0 |-> !earlier_hit);
  // R8
  sel_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_o <= SEL_W'(N));
endmodule

bind fwd_net fwd_net_chk #(
  .DATA_W(DATA_W), .REG_W(REG_W), .NUM_EX(NUM_EX), .NUM_WB(NUM_WB), .OUT_REG(OUT_REG)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .src_reg_i(src_reg_i), .rf_data_i(rf_data_i),
  .ex_data_i(ex_data_i), .ex_dst_i(ex_dst_i), .ex_vld_i(ex_vld_i),
  .wb_data_i(wb_data_i), .wb_dst_i(wb_dst_i), .wb_vld_i(wb_vld_i),
  .sel_o(sel_o), .operand_o(operand_o)
);

// File: tb/sim_fwd_net.sv
`timescale 1ns/1ps
module sim_fwd_net;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic [5:0]  src;
  logic [15:0] rf;
  logic [15:0] d  [8];
  logic [5:0]  ds [8];
  logic        v  [8];

  logic [63:0] ex_data, wb_data;
  logic [23:0] ex_dst, wb_dst;
  logic [3:0]  ex_vld, wb_vld;
  logic [3:0]  sel;
  logic [15:0] op;

  always_comb begin
    for (int k = 0; k < 4; k++) begin
      ex_data[k*16 +: 16] = d[k];
      wb_data[k*16 +: 16] = d[k+4];
      ex_dst[k*6 +: 6]    = ds[k];
      wb_dst[k*6 +: 6]    = ds[k+4];
      ex_vld[k]           = v[k];
      wb_vld[k]           = v[k+4];
    end
  end

  fwd_net u0 (
    .clk_i(clk), .rst_ni(rst_ni), .src_reg_i(src), .rf_data_i(rf),
    .ex_data_i(ex_data), .ex_dst_i(ex_dst), .ex_vld_i(ex_vld),
    .wb_data_i(wb_data), .wb_dst_i(wb_dst), .wb_vld_i(wb_vld),
    .sel_o(sel), .operand_o(op)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic check(input string tag, input int exp_sel, input logic [15:0] exp_op);
    n_chk++;
    if (int'(sel) != exp_sel || op !== exp_op) begin
      n_bad++;
      $display("FAIL %s: sel=%0d op=%h expected sel=%0d op=%h", tag, sel, op, exp_sel, exp_op);
    end
  endtask

  // behavioural reference: first valid match in ex0..ex3, wb0..wb3 order
  task automatic step(input string tag);
    int es = 0;
    logic [15:0] eo = rf;
    for (int i = 0; i < 8; i++) begin
      if (es == 0 && v[i] && ds[i] == src) begin
        es = i + 1;
        eo = d[i];
      end
    end
    @(negedge clk);
    check(tag, es, eo);
  endtask

  task automatic base(input logic [5:0] s);
    src = s;
    rf = 16'hA5A5 ^ {10'd0, s};
    for (int i = 0; i < 8; i++) begin
      d[i]  = 16'h1000 * 16'(i + 1) + 16'h0011 * 16'(i);
      ds[i] = s ^ 6'd1 ^ 6'(i << 1);
      v[i]  = 1'b1;
    end
  endtask

  initial begin
    base(6'd5);
    repeat (3) @(negedge clk);
    check("R7 reset", 0, 16'h0000);
    for (int i = 0; i < 8; i++) ds[i] = src;
    @(negedge clk);
    check("R7 reset hold", 0, 16'h0000);
    rst_ni = 1'b1;

    base(6'd5);
    for (int i = 0; i < 8; i++) v[i] = 1'b0;
    step("R1 all invalid");
    base(6'd17);
    step("R1 valid no match");

    for (int k = 0; k < 8; k++) begin
      base(6'd33);
      ds[k] = src;
      step("R2 single match");
    end

    base(6'd9);
    for (int i = 0; i < 8; i++) begin ds[i] = src; v[i] = 1'b0; end
    step("R3 matching but invalid");
    base(6'd9);
    ds[0] = src; v[0] = 1'b0;
    ds[6] = src;
    step("R3 skip invalid ex0");

    for (int b = 0; b < 6; b++) begin
      base(6'd0);
      ds[b] = src ^ 6'(1 << b);
      ds[b+2] = src ^ 6'(1 << b);
      step("R4 one bit off src0");
      base(6'd63);
      ds[7-b] = src ^ 6'(1 << b);
      step("R4 one bit off src63");
    end

    base(6'd12);
    ds[3] = src; ds[4] = src;
    step("R5 ex3 vs wb0");
    base(6'd12);
    ds[7] = src; ds[2] = src;
    step("R5 ex2 vs wb3");

    base(6'd40);
    ds[1] = src; ds[2] = src;
    step("R6 ex1 vs ex2");
    base(6'd40);
    ds[5] = src; ds[7] = src;
    step("R6 wb1 vs wb3");
    base(6'd40);
    for (int i = 0; i < 8; i++) ds[i] = src;
    step("R6 all match");

    for (int n = 0; n < 400; n++) begin
      src = 6'($urandom_range(0, 3));
      rf = 16'($urandom);
      for (int i = 0; i < 8; i++) begin
        d[i]  = 16'($urandom);
        ds[i] = 6'($urandom_range(0, 3));
        v[i]  = 1'($urandom);
      end
      step("R2 R5 R6 random");
    end

    // R7: held inputs after an asynchronous reset
    @(negedge clk) rst_ni = 1'b0;
    #1 check("R7 async clear", 0, 16'h0000);
    @(negedge clk) rst_ni = 1'b1;
    base(6'd2);
    ds[6] = src;
    step("R7 after re-reset");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule